// File: doc/BRIEF.md
# Hash Engine Command Sequence Checker

This block sits between software and a sponge-based hash engine that can also run a keyed mode. It follows the engine's progress in a small state machine of its own and judges every command that software issues against the current phase. Illegal orderings are reported, and the command is then withheld from the engine: the forwarded command becomes None and the tracked phase stays where it was.

When software starts a new message, the block also validates the configuration it is started with. It checks that the hash family and strength form a supported pair. In keyed mode it also checks that the encoded name prefix matches a fixed tag, and that entropy has been reported ready since the last error acknowledge. Several errors can occur in one cycle, so a single error code is chosen by a fixed priority.

A security escalation input drives the machine into a terminal phase. Only reset leaves that phase.

Top module: `hash_cmd_guard`

## Requirements
- R1: Synchronous active-high reset puts the phase in Idle (`state_o` encoding: Idle 0, MessageFeed 1, Processing 2, Absorbed 3, Squeezing 4, Terminal 5), reports no error and clears the latched entropy-ready flag.
- R2: In Idle only None (0) and Start (1) are legal. Start moves to MessageFeed when `app_active_i` is low and is accepted without effect when it is high.
- R3: In MessageFeed only None and Process (2) are legal. Process moves to Processing.
- R4: In Processing and in Squeezing any command other than None is a sequence error.
- R5: Processing moves to Absorbed only when `absorbed_i` equals exactly 4'b0110. Every other 4-bit value leaves it in Processing.
- R6: In Absorbed the legal commands are None, ManualRun (3) and Done (4). ManualRun moves to Squeezing and Done returns to Idle. Squeezing returns to Absorbed on `perm_done_i`. Command codes 5 to 7 are illegal in every non-terminal phase.
- R7: On the Idle to MessageFeed step, the family/strength pair must be one of two kinds. The first is family 0 with strength 1, 2, 3 or 4. The second is family 1 or 2 with strength 0 or 2. Strength codes are 0=128, 1=224, 2=256, 3=384, 4=512. Any other pair is a mode error.
- R8: On that same step with `keyed_en_i` high, a prefix error is raised when `prefix_i` differs from 48'h4341_4D4B_2001, and an entropy error is raised when the latched ready flag is clear.
- R9: The ready flag is set by `ready_pulse_i` only while the phase is Idle. It is cleared by `err_ack_i`, and the acknowledge wins over a simultaneous pulse.
- R10: A command is blocked on a sequence error, on an entropy error, or on a mode error while `allow_unsup_i` is low. When blocked, `blocked_o` is high, `cmd_fwd_o` is None and the phase holds. A prefix error alone never blocks.
- R11: `err_code_o` reports the highest-priority active error: sequence 1, then mode 2, then prefix 3, then entropy 4. It reports 0 when there is no error. `err_valid_o` is high exactly when the code is nonzero.
- R12: Any `escalate_i` value other than 4'b1010 moves the phase to Terminal at the next edge, from every phase and even when a command is blocked. Terminal is kept until reset, raises no errors and forwards only None.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Software command code |
| app_active_i | input | 1 | Application-side interface owns the engine |
| mode_i | input | 2 | Hash family selector |
| strength_i | input | 3 | Security strength code |
| keyed_en_i | input | 1 | Keyed mode enabled |
| prefix_i | input | 48 | Encoded name prefix for keyed mode |
| allow_unsup_i | input | 1 | Let an unsupported family/strength pair through |
| absorbed_i | input | 4 | Multi-bit absorbed indication |
| perm_done_i | input | 1 | Permutation finished pulse |
| ready_pulse_i | input | 1 | Entropy ready pulse |
| err_ack_i | input | 1 | Error acknowledge, clears the ready flag |
| escalate_i | input | 4 | Multi-bit escalation request |
| state_o | output | 3 | Tracked phase |
| err_valid_o | output | 1 | An error is present this cycle |
| err_code_o | output | 3 | Prioritized error code |
| blocked_o | output | 1 | Current command is withheld |
| cmd_fwd_o | output | 3 | Command passed on to the engine |

## Verification
Squeezing is the hardest phase to reach from the ports. It needs a valid start, a Process, the exact absorbed encoding and then ManualRun, all in order. The bench therefore has a driving routine that walks this chain before each command sweep. Entropy errors need the ready flag in a known state, and the flag can only be set in Idle. Each configuration case therefore issues, or withholds, a ready pulse right after reset and before the Start. A Start with an unsupported pair, a wrong prefix and no entropy gives simultaneous errors, so the priority order is exercised by that same sweep.

// File: rtl/hcg_pkg.sv
package hcg_pkg;

    localparam logic [2:0] CMD_NONE    = 3'd0;
    localparam logic [2:0] CMD_START   = 3'd1;
    localparam logic [2:0] CMD_PROCESS = 3'd2;
    localparam logic [2:0] CMD_RUN     = 3'd3;
    localparam logic [2:0] CMD_DONE    = 3'd4;

    localparam logic [3:0] MB_TRUE = 4'b0110;
    localparam logic [3:0] ESC_OFF = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_FEED = 3'd1,
        ST_PROC = 3'd2,
        ST_ABS  = 3'd3,
        ST_SQZ  = 3'd4,
        ST_TERM = 3'd5
    } phase_e;

    typedef enum logic [2:0] {
        E_NONE    = 3'd0,
        E_SEQ     = 3'd1,
        E_MODE    = 3'd2,
        E_PREFIX  = 3'd3,
        E_ENTROPY = 3'd4
    } err_e;

    typedef struct packed {
        logic seq;
        logic mode;
        logic prefix;
        logic entropy;
    } err_flags_t;

    // Family 0 takes 224/256/384/512, families 1 and 2 take 128/256.
    function automatic logic pair_ok(input logic [1:0] mode, input logic [2:0] strength);
        logic fixed_ok, xof_ok;
        fixed_ok = (mode == 2'd0) && (strength inside {3'd1, 3'd2, 3'd3, 3'd4});
        xof_ok   = (mode inside {2'd1, 2'd2}) && (strength inside {3'd0, 3'd2});
        return fixed_ok || xof_ok;
    endfunction

    function automatic logic esc_is_live(input logic [3:0] v);
        return v != ESC_OFF;
    endfunction

endpackage

// File: rtl/hcg_state_step.sv
module hcg_state_step
    import hcg_pkg::*;
(
    input  phase_e     phase_i,
    input  logic [2:0] cmd_i,
    input  logic       app_active_i,
    input  logic [3:0] absorbed_i,
    input  logic       perm_done_i,
    output phase_e     next_o,
    output logic       seq_err_o
);
    always_comb begin
        next_o    = phase_i;
        seq_err_o = 1'b0;
        case (phase_i)
            ST_IDLE: begin
                seq_err_o = !(cmd_i inside {CMD_NONE, CMD_START});
                if (cmd_i == CMD_START && !app_active_i) next_o = ST_FEED;
            end
            ST_FEED: begin
                seq_err_o = !(cmd_i inside {CMD_NONE, CMD_PROCESS});
                if (cmd_i == CMD_PROCESS) next_o = ST_PROC;
            end
            ST_PROC: begin
                seq_err_o = (cmd_i != CMD_NONE);
                if (absorbed_i == MB_TRUE) next_o = ST_ABS;
            end
            ST_ABS: begin
                seq_err_o = !(cmd_i inside {CMD_NONE, CMD_RUN, CMD_DONE});
                if (cmd_i == CMD_RUN)       next_o = ST_SQZ;
                else if (cmd_i == CMD_DONE) next_o = ST_IDLE;
            end
            ST_SQZ: begin
                seq_err_o = (cmd_i != CMD_NONE);
                if (perm_done_i) next_o = ST_ABS;
            end
            default: next_o = ST_TERM;
        endcase
    end
endmodule

// File: rtl/hcg_cfg_check.sv
module hcg_cfg_check
    import hcg_pkg::*;
#(
    parameter int                   PREFIX_W  = 48,
    parameter logic [PREFIX_W-1:0]  KEYED_TAG = 48'h4341_4D4B_2001
) (
    input  logic                start_i,
    input  logic [1:0]          mode_i,
    input  logic [2:0]          strength_i,
    input  logic                keyed_en_i,
    input  logic [PREFIX_W-1:0] prefix_i,
    input  logic                ready_i,
    output logic                mode_err_o,
    output logic                prefix_err_o,
    output logic                entropy_err_o
);
    logic keyed_start;

    assign keyed_start   = start_i && keyed_en_i;
    assign mode_err_o    = start_i && !pair_ok(mode_i, strength_i);
    assign prefix_err_o  = keyed_start && (prefix_i != KEYED_TAG);
    assign entropy_err_o = keyed_start && !ready_i;
endmodule

// File: rtl/hcg_ready_latch.sv
module hcg_ready_latch (
    input  logic clk,
    input  logic rst,
    input  logic pulse_i,
    input  logic open_i,
    input  logic ack_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)                    flag_q <= 1'b0;
        else if (ack_i)             flag_q <= 1'b0;
        else if (pulse_i && open_i) flag_q <= 1'b1;
    end

    assign flag_o = flag_q;

    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ack_i |=> !flag_o);

    // R9
    pulse_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse_i && open_i && !ack_i) |=> flag_o);
endmodule

// File: rtl/hash_cmd_guard.sv
module hash_cmd_guard
    import hcg_pkg::*;
#(
    parameter int                   PREFIX_W  = 48,
    parameter logic [PREFIX_W-1:0]  KEYED_TAG = 48'h4341_4D4B_2001
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          cmd_i,
    input  logic                app_active_i,
    input  logic [1:0]          mode_i,
    input  logic [2:0]          strength_i,
    input  logic                keyed_en_i,
    input  logic [PREFIX_W-1:0] prefix_i,
    input  logic                allow_unsup_i,
    input  logic [3:0]          absorbed_i,
    input  logic                perm_done_i,
    input  logic                ready_pulse_i,
    input  logic                err_ack_i,
    input  logic [3:0]          escalate_i,
    output logic [2:0]          state_o,
    output logic                err_valid_o,
    output logic [2:0]          err_code_o,
    output logic                blocked_o,
    output logic [2:0]          cmd_fwd_o
);
    phase_e     state_q, step_nxt, state_d;
    err_flags_t errs;
    err_e       code;
    logic       start_evt, ready_flag, esc_hit, block;

    hcg_state_step u_step (
        .phase_i      (state_q),
        .cmd_i        (cmd_i),
        .app_active_i (app_active_i),
        .absorbed_i   (absorbed_i),
        .perm_done_i  (perm_done_i),
        .next_o       (step_nxt),
        .seq_err_o    (errs.seq)
    );

    assign start_evt = (state_q == ST_IDLE) && (step_nxt == ST_FEED);

    hcg_cfg_check #(.PREFIX_W(PREFIX_W), .KEYED_TAG(KEYED_TAG)) u_cfg (
        .start_i       (start_evt),
        .mode_i        (mode_i),
        .strength_i    (strength_i),
        .keyed_en_i    (keyed_en_i),
        .prefix_i      (prefix_i),
        .ready_i       (ready_flag),
        .mode_err_o    (errs.mode),
        .prefix_err_o  (errs.prefix),
        .entropy_err_o (errs.entropy)
    );

    hcg_ready_latch u_rdy (
        .clk     (clk),
        .rst     (rst),
        .pulse_i (ready_pulse_i),
        .open_i  (state_q == ST_IDLE),
        .ack_i   (err_ack_i),
        .flag_o  (ready_flag)
    );

    assign esc_hit = esc_is_live(escalate_i);
    assign block   = errs.seq | (errs.mode & ~allow_unsup_i) | errs.entropy;

    always_comb begin
        if (errs.seq)          code = E_SEQ;
        else if (errs.mode)    code = E_MODE;
        else if (errs.prefix)  code = E_PREFIX;
        else if (errs.entropy) code = E_ENTROPY;
        else                   code = E_NONE;
    end

    always_comb begin
        if (esc_hit)    state_d = ST_TERM;
        else if (block) state_d = state_q;
        else            state_d = step_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state_o     = state_q;
    assign err_code_o  = code;
    assign err_valid_o = (code != E_NONE);
    assign blocked_o   = block;
    assign cmd_fwd_o   = (block || state_q == ST_TERM) ? CMD_NONE : cmd_i;

    // R12
    term_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TERM) |=> (state_q == ST_TERM));

    // R12
    esc_forces_term_chk: assert property (@(posedge clk) disable iff (rst)
        esc_hit |=> (state_q == ST_TERM));

    // R10
    block_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (block && !esc_hit) |=> $stable(state_q));

    // R5
    absorb_strict_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PROC && !esc_hit && absorbed_i != MB_TRUE) |=> (state_q == ST_PROC));
endmodule

// File: tb/sim_hash_cmd_guard.sv
module sim_hash_cmd_guard;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd = 3'd0;
    logic        app = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [2:0]  strength = 3'd2;
    logic        keyed = 1'b0;
    logic [47:0] prefix = 48'h4341_4D4B_2001;
    logic        allow = 1'b0;
    logic [3:0]  absorbed = 4'd0;
    logic        perm = 1'b0;
    logic        pulse = 1'b0;
    logic        ack = 1'b0;
    logic [3:0]  esc = 4'b1010;
    logic [2:0]  state_o, err_code_o, cmd_fwd_o;
    logic        err_valid_o, blocked_o;

    localparam logic [47:0] TAG = 48'h4341_4D4B_2001;

    int checks = 0;
    int errors = 0;
    int m_state = 0;
    bit m_flag = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    hash_cmd_guard u0 (
        .clk(clk), .rst(rst), .cmd_i(cmd), .app_active_i(app), .mode_i(mode),
        .strength_i(strength), .keyed_en_i(keyed), .prefix_i(prefix),
        .allow_unsup_i(allow), .absorbed_i(absorbed), .perm_done_i(perm),
        .ready_pulse_i(pulse), .err_ack_i(ack), .escalate_i(esc),
        .state_o(state_o), .err_valid_o(err_valid_o), .err_code_o(err_code_o),
        .blocked_o(blocked_o), .cmd_fwd_o(cmd_fwd_o)
    );

    task automatic check_val(input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", cur_req, what, got, exp);
        end
    endtask

    task automatic quiet();
        cmd = 0; app = 0; perm = 0; pulse = 0; ack = 0; esc = 4'b1010;
        absorbed = 0; allow = 0; keyed = 0; mode = 0; strength = 2; prefix = TAG;
    endtask

    // One clock: called at a falling edge with the inputs already set.
    task automatic cycle();
        bit seq, st_evt, me, pe, ee, blk, ok, fl_n;
        int step, code, fwd, nxt;
        #2;
        case (m_state)
            0: begin seq = !(cmd == 0 || cmd == 1); step = (cmd == 1 && !app) ? 1 : 0; end
            1: begin seq = !(cmd == 0 || cmd == 2); step = (cmd == 2) ? 2 : 1; end
            2: begin seq = (cmd != 0); step = (absorbed == 4'b0110) ? 3 : 2; end
            3: begin seq = !(cmd == 0 || cmd == 3 || cmd == 4);
                     step = (cmd == 3) ? 4 : (cmd == 4) ? 0 : 3; end
            4: begin seq = (cmd != 0); step = perm ? 3 : 4; end
            default: begin seq = 0; step = 5; end
        endcase
        st_evt = (m_state == 0) && (step == 1);
        ok = (mode == 0 && strength >= 1 && strength <= 4) ||
             ((mode == 1 || mode == 2) && (strength == 0 || strength == 2));
        me = st_evt && !ok;
        pe = st_evt && keyed && (prefix != TAG);
        ee = st_evt && keyed && !m_flag;
        blk = seq || (me && !allow) || ee;
        code = seq ? 1 : me ? 2 : pe ? 3 : ee ? 4 : 0;
        fwd = (blk || m_state == 5) ? 0 : int'(cmd);
        nxt = (esc != 4'b1010) ? 5 : blk ? m_state : step;
        fl_n = ack ? 1'b0 : (pulse && m_state == 0) ? 1'b1 : m_flag;
        check_val("err_code", int'(err_code_o), code);
        check_val("err_valid", int'(err_valid_o), int'(code != 0));
        check_val("blocked", int'(blocked_o), int'(blk));
        check_val("cmd_fwd", int'(cmd_fwd_o), fwd);
        @(posedge clk);
        if (rst) begin m_state = 0; m_flag = 0; end
        else begin m_state = nxt; m_flag = fl_n; end
        @(negedge clk);
        check_val("state", int'(state_o), m_state);
    endtask

    task automatic do_reset();
        quiet();
        rst = 1;
        @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_state = 0; m_flag = 0;
    endtask

    task automatic drive_to(input int s);
        if (s >= 1) begin quiet(); cmd = 1; cycle(); end
        if (s >= 2) begin quiet(); cmd = 2; cycle(); end
        if (s >= 3) begin quiet(); absorbed = 4'b0110; cycle(); end
        if (s >= 4) begin quiet(); cmd = 3; cycle(); end
        quiet();
    endtask

    initial begin : watchdog
        int n = 0;
        forever begin
            @(posedge clk);
            n++;
            if (n > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin : main
        bit [31:0] r;
        @(negedge clk);
        do_reset();
        cur_req = "R1";
        check_val("state", int'(state_o), 0);
        check_val("err_valid", int'(err_valid_o), 0);
        keyed = 1; cmd = 1; cycle();   // flag clear after reset: entropy error

        // Command sweep in each phase
        for (int s = 0; s < 5; s++) begin
            for (int c = 0; c < 8; c++) begin
                for (int a = 0; a < 2; a++) begin
                    do_reset();
                    drive_to(s);
                    case (s)
                        0: cur_req = "R2";
                        1: cur_req = "R3";
                        3: cur_req = "R6";
                        default: cur_req = "R4";
                    endcase
                    cmd = 3'(c); app = a[0];
                    cycle();
                end
            end
        end
        cur_req = "R6";
        do_reset(); drive_to(4); perm = 1; cycle(); quiet(); cmd = 4; cycle();

        // Absorbed indication sweep
        cur_req = "R5";
        for (int v = 0; v < 16; v++) begin
            do_reset(); drive_to(2);
            absorbed = 4'(v); cycle();
        end

        // Configuration sweep on Start
        for (int m = 0; m < 4; m++)
            for (int st = 0; st < 8; st++)
                for (int k = 0; k < 16; k++) begin
                    do_reset();
                    if (k[2]) begin cur_req = "R9"; pulse = 1; cycle(); quiet(); end
                    cur_req = k[0] ? "R8" : (k[3] ? "R10" : "R7");
                    if (k[1] && k[2]) cur_req = "R11";
                    mode = 2'(m); strength = 3'(st); keyed = k[0];
                    prefix = k[1] ? 48'h0000_0000_0001 : TAG;
                    allow = k[3]; cmd = 1;
                    cycle();
                end

        // Ready flag ordering
        cur_req = "R9";
        do_reset(); pulse = 1; ack = 1; cycle(); quiet(); keyed = 1; cmd = 1; cycle();
        do_reset(); drive_to(1); pulse = 1; cycle(); quiet(); cmd = 2; cycle();
        quiet(); absorbed = 4'b0110; cycle(); quiet(); cmd = 4; cycle();
        quiet(); keyed = 1; cmd = 1; cycle();
        do_reset(); pulse = 1; cycle(); quiet(); ack = 1; cycle(); quiet(); keyed = 1; cmd = 1; cycle();
        do_reset(); pulse = 1; cycle(); quiet(); keyed = 1; cmd = 1; cycle();

        // Escalation from each phase, every encoding
        cur_req = "R12";
        for (int s = 0; s < 5; s++)
            for (int e = 0; e < 16; e++) begin
                do_reset(); drive_to(s);
                esc = 4'(e); cmd = 3'(e % 8); cycle();
                quiet(); cmd = 1; cycle();
                quiet(); cmd = 4; pulse = 1; cycle();
            end

        // Long pseudo-random run against the model
        cur_req = "R10";
        do_reset();
        r = 32'h1234_5678;
        for (int i = 0; i < 6000; i++) begin
            r ^= r << 13; r ^= r >> 17; r ^= r << 5;
            cmd = (r[2:0] > 4) && r[3] ? 3'(r[2:0]) : 3'(r[2:0] % 5);
            app = r[4] & r[5];
            mode = r[7:6]; strength = r[10:8] % 5;
            keyed = r[11]; prefix = (r[12] & r[13]) ? 48'h1 : TAG;
            allow = r[14];
            absorbed = r[15] ? 4'b0110 : r[19:16];
            perm = r[20]; pulse = r[21]; ack = r[22] & r[23];
            esc = (r[30:24] == 0) ? r[31:28] : 4'b1010;
            rst = (r[31:25] == 7'h55) || (m_state == 5 && r[26]);
            cycle();
            rst = 0;
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule